// File: doc/BRIEF.md
# Crank Angle Clock Generator

This block turns a toothed crank-wheel signal into a fine-grained engine angle count. A free-running cycle counter times every tooth interval. The block then issues 512 evenly spaced angle sub-ticks across the next interval, paced by the interval just measured. The running angle therefore advances in real time between teeth. Downstream compare logic can match it against a target angle to launch injector or ignition events.

The wheel is described by two static settings: the number of tooth positions per revolution, which includes the missing ones, and the number of missing teeth. A stretched interval marks the missing-tooth gap, and the block locks onto it. Once locked, the angle counts through the missing positions with the same spacing and wraps once per revolution. Lock is dropped in three cases: a gap turns up at the wrong tooth, the expected gap fails to appear, or the wheel stalls past a timeout.

Top module: `crank_angle_gen`

## Requirements
- R1: `toothPeriod` shows the number of clock cycles between the two most recent tooth pulses. It updates in the cycle after a pulse.
- R2: While locked, after an ordinary tooth interval of P cycles, the angle n cycles after the next pulse equals the tooth's base angle plus floor(512·n/P).
- R3: Once a tooth's full share of sub-ticks has been issued, the angle holds until the next pulse.
- R4: In the cycle after a locked tooth pulse, the angle equals the tooth index × 512, with index 0 at the pulse that ends the gap. Any unissued sub-ticks are skipped over at once.
- R5: A pulse is a gap when its interval exceeds P + floor(P/2), where P is the previous interval. At least two earlier pulses must have been seen since reset or since a timeout. A gap while unlocked sets `syncValid` and puts the angle at 0.
- R6: The interval after the last real tooth carries (missing+1)·512 sub-ticks. The interval after the gap uses spacing Pgap/((missing+1)·512), so the missing positions are still counted.
- R7: The angle wraps to 0 after reaching teeth·512 − 1.
- R8: A gap at any tooth index other than the last real one clears `syncValid`.
- R9: An ordinary pulse where the gap was expected clears `syncValid`.
- R10: If no pulse arrives while the cycle counter is at or above `cfgTimeout`, `syncValid` clears and gap detection restarts.
- R11: After reset, and whenever `syncValid` is low, `angle` is 0 and `subTick` is low. After reset `toothPeriod` is also 0.
- R12: `subTick` is high exactly in the cycles where the angle moved forward by one interpolated count. A skip on a tooth pulse does not raise it.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| toothPulse | input | 1 | Synchronised one-cycle pulse per tooth edge |
| cfgTeeth | input | TEETH_W | Tooth positions per revolution, missing ones included |
| cfgMissing | input | TEETH_W | Missing teeth in the gap |
| cfgTimeout | input | TIME_W | Stall limit in cycles |
| angle | output | TEETH_W+SUB_BITS | Running angle count |
| subTick | output | 1 | One interpolated angle step was issued |
| syncValid | output | 1 | Locked to the wheel's gap |
| toothPeriod | output | TIME_W | Last measured tooth interval in cycles |

## Verification
The assertions assume several things about the inputs. `toothPulse` is one cycle wide. The three settings stay fixed while the block runs. Every locked interval is at least 512 × span cycles, so at most one sub-tick falls due per cycle. The stall limit is longer than any gap. The stimulus holds the settings constant and uses tooth intervals between 520 and 5000 cycles. It makes the gap more than 1024 cycles and 1.5 times the previous tooth, and places the stall limit at 4000 cycles. Within those bounds, every sampled cycle of every interval is compared against the floor formula.

// File: rtl/crank_angle_pkg.sv
`timescale 1ns/1ps
package crank_angle_pkg;
  // strobes from the sync control to the interpolation datapath
  typedef struct packed {
    logic toothEdge;  // a tooth pulse is being taken this cycle
    logic gapEdge;    // this pulse closes a missing-tooth gap
    logic syncNext;   // lock state after this cycle
    logic gapNext;    // the interval now starting spans the gap
  } ctrlStrobes_t;
endpackage

// File: rtl/crank_sync_ctrl.sv
`timescale 1ns/1ps
module crank_sync_ctrl
  import crank_angle_pkg::*;
#(
  parameter int TIME_W  = 20,
  parameter int TEETH_W = 10
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               toothPulse,
  input  logic [TEETH_W-1:0] cfgTeeth,
  input  logic [TEETH_W-1:0] cfgMissing,
  input  logic [TIME_W-1:0]  cfgTimeout,
  input  logic [TIME_W-1:0]  sinceEdge,
  input  logic [TIME_W-1:0]  lastPeriod,
  output ctrlStrobes_t       strobes,
  output logic [TEETH_W-1:0] snapIdx,
  output logic               syncValid
);
  logic [1:0]         edgesSeen, edgesN;
  logic [TEETH_W-1:0] toothIdx, idxN, lastReal;
  logic               syncQ, syncN, isGap, timeoutHit;
  logic [TIME_W+1:0]  gapLimit;

  assign lastReal   = cfgTeeth - cfgMissing - 1'b1;
  assign gapLimit   = {2'b00, lastPeriod} + {3'b000, lastPeriod[TIME_W-1:1]};
  assign isGap      = (edgesSeen == 2'd2) && ({2'b00, sinceEdge} > gapLimit);
  assign timeoutHit = sinceEdge >= cfgTimeout;

  always_comb begin
    syncN  = syncQ;
    idxN   = toothIdx;
    edgesN = edgesSeen;
    if (toothPulse) begin
      if (edgesSeen != 2'd2) edgesN = edgesSeen + 2'd1;
      if (isGap) begin
        idxN  = '0;
        syncN = !syncQ || (toothIdx == lastReal);
      end else if (syncQ) begin
        if (toothIdx == lastReal) syncN = 1'b0;
        else                      idxN  = toothIdx + 1'b1;
      end
    end else if (timeoutHit) begin
      syncN  = 1'b0;
      edgesN = 2'd0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      syncQ     <= 1'b0;
      toothIdx  <= '0;
      edgesSeen <= 2'd0;
    end else begin
      syncQ     <= syncN;
      toothIdx  <= idxN;
      edgesSeen <= edgesN;
    end
  end

  assign strobes.toothEdge = toothPulse;
  assign strobes.gapEdge   = toothPulse && isGap;
  assign strobes.syncNext  = syncN;
  assign strobes.gapNext   = syncN && (idxN == lastReal);
  assign snapIdx           = idxN;
  assign syncValid         = syncQ;

  // lock is only ever gained on a tooth pulse
  assert_lock_on_pulse_R5: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(syncQ) |-> $past(toothPulse));
  // a locked tooth index never passes the last real tooth
  assert_index_range_R4: assert property (@(posedge clk) disable iff (!rst_n)
    syncQ |-> (toothIdx <= lastReal));
  // while locked the stall counter never goes past the limit
  assert_stall_bound_R10: assert property (@(posedge clk) disable iff (!rst_n)
    syncQ |-> (sinceEdge <= cfgTimeout));
endmodule

// File: rtl/crank_interp_dp.sv
`timescale 1ns/1ps
module crank_interp_dp
  import crank_angle_pkg::*;
#(
  parameter int TIME_W   = 20,
  parameter int TEETH_W  = 10,
  parameter int SUB_BITS = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic [TEETH_W-1:0]          cfgTeeth,
  input  logic [TEETH_W-1:0]          cfgMissing,
  input  ctrlStrobes_t                strobes,
  input  logic [TEETH_W-1:0]          snapIdx,
  output logic [TIME_W-1:0]           sinceEdge,
  output logic [TIME_W-1:0]           lastPeriod,
  output logic [TEETH_W+SUB_BITS-1:0] angle,
  output logic                        subTick
);
  localparam int SPAN_W  = TEETH_W + 1;
  localparam int CNT_W   = SPAN_W + SUB_BITS;
  localparam int ACC_W   = TIME_W + 1;
  localparam int ANGLE_W = TEETH_W + SUB_BITS;

  logic [SPAN_W-1:0]  stepSpan, budSpan, gapSpan;
  logic [ACC_W-1:0]   acc, accSum, stepVal, periodExt;
  logic [CNT_W-1:0]   subCnt, budget;
  logic [ANGLE_W-1:0] maxAngle;
  logic               tickDue;

  assign gapSpan   = {1'b0, cfgMissing} + 1'b1;
  assign stepVal   = ACC_W'({stepSpan, {SUB_BITS{1'b0}}});
  assign budget    = {budSpan, {SUB_BITS{1'b0}}};
  assign periodExt = {1'b0, lastPeriod};
  assign accSum    = acc + stepVal;
  assign tickDue   = accSum >= periodExt;
  assign maxAngle  = {cfgTeeth, {SUB_BITS{1'b0}}} - 1'b1;

  // time base and interval capture
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      sinceEdge  <= '0;
      lastPeriod <= '0;
      stepSpan   <= SPAN_W'(1);
      budSpan    <= SPAN_W'(1);
    end else if (strobes.toothEdge) begin
      sinceEdge  <= TIME_W'(1);
      lastPeriod <= sinceEdge;
      stepSpan   <= strobes.gapEdge ? gapSpan : SPAN_W'(1);
      budSpan    <= strobes.gapNext ? gapSpan : SPAN_W'(1);
    end else if (sinceEdge != '1) begin
      sinceEdge  <= sinceEdge + 1'b1;
    end
  end

  // fractional accumulator spreading sub-ticks over the interval
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      acc     <= '0;
      subCnt  <= '0;
      angle   <= '0;
      subTick <= 1'b0;
    end else begin
      subTick <= 1'b0;
      if (!strobes.syncNext) begin
        acc    <= '0;
        subCnt <= '0;
        angle  <= '0;
      end else if (strobes.toothEdge) begin
        acc    <= '0;
        subCnt <= '0;
        angle  <= {snapIdx, {SUB_BITS{1'b0}}};
      end else if (subCnt < budget) begin
        if (tickDue) begin
          acc     <= accSum - periodExt;
          subCnt  <= subCnt + 1'b1;
          subTick <= 1'b1;
          angle   <= (angle == maxAngle) ? '0 : angle + 1'b1;
        end else begin
          acc <= accSum;
        end
      end
    end
  end

  assert_angle_range_R7: assert property (@(posedge clk) disable iff (!rst_n)
    angle <= maxAngle);
  assert_tick_step_R12: assert property (@(posedge clk) disable iff (!rst_n)
    subTick |-> ((angle == $past(angle) + 1'b1) ||
                 (angle == '0 && $past(angle) == maxAngle)));
  assert_budget_cap_R3: assert property (@(posedge clk) disable iff (!rst_n)
    subCnt <= budget);
  assert_period_hold_R1: assert property (@(posedge clk) disable iff (!rst_n)
    !strobes.toothEdge |=> $stable(lastPeriod));
endmodule

// File: rtl/crank_angle_gen.sv
`timescale 1ns/1ps
module crank_angle_gen
  import crank_angle_pkg::*;
#(
  parameter int TIME_W   = 20,
  parameter int TEETH_W  = 10,
  parameter int SUB_BITS = 9
) (
  input  logic                        clk,
  input  logic                        rst_n,
  input  logic                        toothPulse,
  input  logic [TEETH_W-1:0]          cfgTeeth,
  input  logic [TEETH_W-1:0]          cfgMissing,
  input  logic [TIME_W-1:0]           cfgTimeout,
  output logic [TEETH_W+SUB_BITS-1:0] angle,
  output logic                        subTick,
  output logic                        syncValid,
  output logic [TIME_W-1:0]           toothPeriod
);
  ctrlStrobes_t       strobes;
  logic [TEETH_W-1:0] snapIdx;
  logic [TIME_W-1:0]  sinceEdge;

  crank_sync_ctrl #(.TIME_W(TIME_W), .TEETH_W(TEETH_W)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .toothPulse(toothPulse),
    .cfgTeeth(cfgTeeth), .cfgMissing(cfgMissing), .cfgTimeout(cfgTimeout),
    .sinceEdge(sinceEdge), .lastPeriod(toothPeriod),
    .strobes(strobes), .snapIdx(snapIdx), .syncValid(syncValid)
  );

  crank_interp_dp #(.TIME_W(TIME_W), .TEETH_W(TEETH_W), .SUB_BITS(SUB_BITS)) u_dp (
    .clk(clk), .rst_n(rst_n), .cfgTeeth(cfgTeeth), .cfgMissing(cfgMissing),
    .strobes(strobes), .snapIdx(snapIdx), .sinceEdge(sinceEdge),
    .lastPeriod(toothPeriod), .angle(angle), .subTick(subTick)
  );

  // unlocked means parked at zero with no steps
  assert_unlocked_idle_R11: assert property (@(posedge clk) disable iff (!rst_n)
    !syncValid |-> (angle == '0 && !subTick));
endmodule

// File: tb/sim_crank_angle_gen.sv
`timescale 1ns/1ps
module sim_crank_angle_gen;
  localparam int TIME_W = 20, TEETH_W = 10, SUB_BITS = 9;
  localparam int SUBS = 512, TEETH = 6, MISS = 1, TOUT = 4000;
  localparam int TOTAL = TEETH * SUBS, LAST_REAL = TEETH - MISS - 1;

  logic clk = 1'b0, rst_n = 1'b0, toothPulse = 1'b0;
  logic [TEETH_W-1:0] cfgTeeth = TEETH_W'(TEETH);
  logic [TEETH_W-1:0] cfgMissing = TEETH_W'(MISS);
  logic [TIME_W-1:0]  cfgTimeout = TIME_W'(TOUT);
  logic [TEETH_W+SUB_BITS-1:0] angle;
  logic subTick, syncValid;
  logic [TIME_W-1:0] toothPeriod;

  crank_angle_gen #(.TIME_W(TIME_W), .TEETH_W(TEETH_W), .SUB_BITS(SUB_BITS)) u0 (
    .clk(clk), .rst_n(rst_n), .toothPulse(toothPulse), .cfgTeeth(cfgTeeth),
    .cfgMissing(cfgMissing), .cfgTimeout(cfgTimeout), .angle(angle),
    .subTick(subTick), .syncValid(syncValid), .toothPeriod(toothPeriod)
  );

  always #2.5 clk = ~clk;

  int checks = 0, errors = 0;
  bit finished = 0;
  // requirement model state
  int mSync = 0, mEdges = 0, mIdx = 0, mP = 0, mPrevP = 0, mKnow = 0;
  int mStep = 1, mBud = 1, mBase = 0;
  string sTag = "R11";

  task automatic chk(string req, int act, int exp);
    checks++;
    if (act != exp) begin
      errors++;
      $display("FAIL %s: actual %0d expected %0d", req, act, exp);
    end
  endtask

  function automatic int ticksAt(int n);
    int t = (n * SUBS * mStep) / mP;
    if (t > mBud * SUBS) t = mBud * SUBS;
    return t;
  endfunction

  task automatic checkPoint(int n);
    int t, tp;
    string tag;
    if (n >= TOUT) begin
      mEdges = 0;
      if (mSync != 0) begin mSync = 0; sTag = "R10"; end
    end
    chk(sTag, int'(syncValid), mSync);
    if (mSync == 0) begin
      chk("R11", int'(angle), 0);
      chk("R11", int'(subTick), 0);
    end else begin
      t  = ticksAt(n);
      tp = (n > 0) ? ticksAt(n - 1) : 0;
      if (n == 0)                        tag = "R4";
      else if (t == mBud * SUBS)         tag = "R3";
      else if (mStep > 1 || mBud > 1)    tag = "R6";
      else                               tag = "R2";
      if (mBase + t >= TOTAL)            tag = "R7";
      chk(tag, int'(angle), (mBase + t) % TOTAL);
      chk("R12", int'(subTick), (n > 0 && t != tp) ? 1 : 0);
    end
    if (n == 0 && mKnow >= 2) chk("R1", int'(toothPeriod), mP);
  endtask

  task automatic modelEdge(int len);
    bit gap;
    gap = (mEdges >= 2) && (len > mPrevP + mPrevP / 2);
    if (mEdges < 2) mEdges++;
    if (gap) begin
      if (mSync == 0 || mIdx == LAST_REAL) begin mSync = 1; sTag = "R5"; end
      else begin mSync = 0; sTag = "R8"; end
      mIdx = 0;
    end else if (mSync != 0) begin
      if (mIdx == LAST_REAL) begin mSync = 0; sTag = "R9"; end
      else mIdx++;
    end
    mStep  = gap ? MISS + 1 : 1;
    mBud   = (mSync != 0 && mIdx == LAST_REAL) ? MISS + 1 : 1;
    mBase  = mIdx * SUBS;
    mP     = len;
    mPrevP = len;
    mKnow++;
  endtask

  // one tooth interval of len cycles, checked every cycle
  task automatic tooth(int len);
    for (int n = 0; n < len; n++) begin
      checkPoint(n);
      if (n == len - 1) toothPulse = 1'b1;
      @(negedge clk);
      toothPulse = 1'b0;
    end
    modelEdge(len);
  endtask

  task automatic summary();
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
  endtask

  initial begin
    repeat (5) @(negedge clk);
    rst_n = 1'b1;
    // R11 reset state
    chk("R11", int'(angle), 0);
    chk("R11", int'(subTick), 0);
    chk("R11", int'(syncValid), 0);
    chk("R11", int'(toothPeriod), 0);
    // acquire lock: R5
    tooth(600); tooth(600); tooth(600);
    tooth(1300);
    // revolutions at several speeds: R2, R3, R4, R6, R7, R12
    for (int r = 0; r < 4; r++) begin
      int b = 530 + 60 * r;
      tooth(b + ((r % 2 != 0) ? -10 : 30));
      tooth(b + 70);
      tooth(b);
      tooth(b + 40);
      tooth(2 * b + 150);
    end
    // R8 gap at the wrong tooth
    tooth(600); tooth(1400);
    tooth(600); tooth(1300);
    // R9 expected gap absent
    tooth(600); tooth(600); tooth(600); tooth(600); tooth(600);
    tooth(1300);
    // R10 stall past the limit, then relock
    tooth(600); tooth(5000);
    tooth(600); tooth(1300);
    tooth(700); tooth(650);
    finished = 1;
    summary();
    $finish;
  end

  initial begin
    repeat (200000) @(posedge clk);
    if (!finished) begin
      errors++;
      $display("FAIL R2: watchdog actual hung expected done");
      summary();
      $finish;
    end
  end
endmodule